// File: doc/BRIEF.md
# Two-Decade Push-Button Decimal Counter

This block counts manual button presses in decimal, from 00 up to 99, holding each digit as a four-bit binary coded decimal value. The raw button level goes through a two-stage synchronizer and a debouncer. Then a rising-edge detector turns each accepted press into a single-cycle step. The units decade takes every step. The tens decade moves only when the units decade rolls over, so the pair behaves like one counter.

When a step takes the count from 99 to 00, the block raises a carry flag for one cycle. The flag uses the same timing as the internal decade-to-decade enable, so a further decade can be chained on to extend the range to 999. The decade stage is one reusable module, and the top instantiates it once per digit. If a digit register ever held an unused code, the next step would force it back to zero.

Top module: `bcd_press_counter`

## Requirements
- R1: While rst_n is low at a rising clock edge, both digits are cleared to 0000 and carry_o is cleared to 0. The debouncer returns to the released state.
- R2: units_o and tens_o only ever show the ten codes 0000 through 1001.
- R3: Each accepted press advances units_o by one, where 1001 is followed by 0000. Presses that leave units_o below 1001 do not change tens_o.
- R4: tens_o advances by one exactly when a press moves units_o from 1001 to 0000.
- R5: A press at count 99 returns both digits to 00. carry_o is high for exactly one clock, in the first cycle in which the outputs show 00, and it is low at every other time.
- R6: Holding btn_i high for any length of time produces exactly one step, and releasing it produces none.
- R7: A change of the button level that lasts fewer than DEBOUNCE_CYCLES clocks has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_i | input | 1 | Raw, asynchronous push-button level (1 = pressed) |
| units_o | output | 4 | Units digit, BCD |
| tens_o | output | 4 | Tens digit, BCD |
| carry_o | output | 1 | One-cycle pulse on the rollover from 99 to 00 |

## Verification
A wrong debouncer or edge detector shows up as a press that is lost or counted twice. The digits are off by one within a few dozen clocks of that press and stay off from then on. A wrong decade shows up as a skipped or illegal code, or as a tens digit that moves at the wrong time, and the next compared press exposes it. A wrong carry is seen on the rollover cycle itself: the pulse is missing, too wide, or not aligned with the 00 display. The sweep passes through every count value twice, so every digit transition is observed.

// File: rtl/bcd_press_pkg.sv
// Package: shared types and constants for the push-button decimal counter.
// Assumes four-bit BCD digits holding codes 0 through 9.
package bcd_press_pkg;
    typedef logic [3:0] bcd_t;
    localparam bcd_t BCD_TOP  = 4'd9;
    localparam bcd_t BCD_ZERO = 4'd0;
endpackage

// File: rtl/press_conditioner.sv
// Module: press_conditioner
// Turns a raw asynchronous button level into a one-cycle step pulse.
// A two-flop synchronizer feeds a debouncer, which accepts a new level only
// after it has differed from the accepted level for DEBOUNCE_CYCLES
// consecutive clocks. A rising-edge detector then marks each accepted press.
// Assumes DEBOUNCE_CYCLES >= 1. Reset is synchronous and active low.
module press_conditioner #(
    parameter int DEBOUNCE_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic step_o
);
    localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

    logic          sync_a_q, sync_b_q;
    logic          level_q, level_prev_q;
    logic [CW-1:0] hold_cnt_q;

    // Two-stage synchronizer for the raw button input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a_q <= 1'b0;
            sync_b_q <= 1'b0;
        end else begin
            sync_a_q <= raw_i;
            sync_b_q <= sync_a_q;
        end
    end

    // Debounce: count consecutive cycles of disagreement, accept on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q    <= 1'b0;
            hold_cnt_q <= '0;
        end else if (sync_b_q == level_q) begin
            hold_cnt_q <= '0;
        end else if (hold_cnt_q == LAST) begin
            level_q    <= sync_b_q;
            hold_cnt_q <= '0;
        end else begin
            hold_cnt_q <= hold_cnt_q + 1'b1;
        end
    end

    // Delayed copy of the accepted level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_prev_q <= 1'b0;
        else        level_prev_q <= level_q;
    end

    // Rising edge of the accepted level gives the step.
    always_comb step_o = level_q & ~level_prev_q;

    // R6: a step never lasts more than one cycle.
    p_step_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R7: the accepted level changes only after the synchronized level has disagreed.
    p_level_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != level_prev_q) |-> (level_q == $past(sync_b_q)));
endmodule

// File: rtl/bcd_decade.sv
// Module: bcd_decade
// One BCD digit that advances by one on each enabled cycle, with 9 followed by 0.
// wrap_o flags an enabled cycle at digit 9, so it can enable the next decade.
// An unused code (10..15) is forced to 0 on the next enabled cycle.
// Reset is synchronous and active low.
module bcd_decade
    import bcd_press_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output bcd_t digit_o,
    output logic wrap_o
);
    bcd_t digit_q;

    // Digit register: advance, or return to zero at 9 and above.
    always_ff @(posedge clk) begin
        if (!rst_n)                digit_q <= BCD_ZERO;
        else if (en_i) begin
            if (digit_q >= BCD_TOP) digit_q <= BCD_ZERO;
            else                    digit_q <= digit_q + 4'd1;
        end
    end

    // Rollover indication toward the next decade.
    always_comb wrap_o = en_i && (digit_q == BCD_TOP);

    always_comb digit_o = digit_q;

    // R2: the digit register holds only legal BCD codes.
    p_digit_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        digit_q <= BCD_TOP);

    // R3: without an enable, the digit holds.
    p_digit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(digit_q));

    // R3: an enabled digit below 9 goes up by exactly one.
    p_digit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && digit_q < BCD_TOP) |=> (digit_q == $past(digit_q) + 4'd1));

    // R4: a wrap leaves the digit at zero.
    p_digit_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (digit_q == BCD_ZERO));
endmodule

// File: rtl/bcd_press_counter.sv
// Module: bcd_press_counter (top)
// Two cascaded BCD decades that step once per debounced button press, plus a
// registered one-cycle carry on the rollover from 99 to 00.
// Assumes a single clock domain apart from the raw button.
// Reset is synchronous and active low.
module bcd_press_counter
    import bcd_press_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 65536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_i,
    output logic [3:0] units_o,
    output logic [3:0] tens_o,
    output logic       carry_o
);
    localparam int NUM_DECADES = 2;

    logic step;
    logic [NUM_DECADES:0] chain_en;
    bcd_t digits [NUM_DECADES];
    logic carry_q;

    press_conditioner #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) i_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (btn_i),
        .step_o (step)
    );

    // The first decade takes every step.
    always_comb chain_en[0] = step;

    // One decade per digit, each enabled by the wrap of the one below.
    for (genvar g = 0; g < NUM_DECADES; g++) begin : g_decade
        bcd_decade i_decade (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (chain_en[g]),
            .digit_o (digits[g]),
            .wrap_o  (chain_en[g+1])
        );
    end

    // Carry register, aligned with the digits returning to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= chain_en[NUM_DECADES];
    end

    always_comb begin
        units_o = digits[0];
        tens_o  = digits[1];
        carry_o = carry_q;
    end

    // R5: the carry coincides with an all-zero display.
    p_carry_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> (units_o == 4'd0 && tens_o == 4'd0));

    // R5: the carry is a single-cycle pulse.
    p_carry_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> !carry_o);

    // R4: the tens digit moves only while the units digit goes to zero.
    p_tens_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tens_o != $past(tens_o)) |-> (units_o == 4'd0));
endmodule

// File: tb/test_bcd_press_counter.sv
// Bench: press sweep over two full count cycles, with glitch and long-hold cases.
module test_bcd_press_counter;
    localparam int DEB = 4;
    localparam int GAP = DEB + 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn = 1'b0;
    logic [3:0] units, tens;
    logic carry;

    int checks = 0;
    int errors = 0;
    int carry_seen = 0;
    int presses = 0;
    bit carry_prev = 1'b0;

    always #2.5 clk = ~clk;

    bcd_press_counter #(.DEBOUNCE_CYCLES(DEB)) i_bcd_press_counter (
        .clk(clk), .rst_n(rst_n), .btn_i(btn),
        .units_o(units), .tens_o(tens), .carry_o(carry)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_count(input string req);
        check({req, " units"}, int'(units), presses % 10);
        check({req, " tens"}, int'(tens), (presses / 10) % 10);
    endtask

    task automatic press(input int hold);
        btn = 1'b1;
        repeat (hold) @(posedge clk);
        btn = 1'b0;
        repeat (GAP) @(posedge clk);
        presses++;
        @(negedge clk);
    endtask

    // Carry monitor at the falling edge: count pulses, width and alignment (R5).
    always @(negedge clk) begin
        if (rst_n) begin
            if (carry) begin
                carry_seen++;
                checks++;
                if (units != 0 || tens != 0) begin
                    errors++;
                    $display("FAIL R5 carry with count actual=%0d%0d expected=00", tens, units);
                end
                if (carry_prev) begin
                    errors++;
                    $display("FAIL R5 carry width actual=2+ expected=1");
                end
            end
            if (units > 9 || tens > 9) begin
                errors++;
                $display("FAIL R2 illegal code actual=%0d/%0d expected<=9", tens, units);
            end
        end
        carry_prev = carry;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 units after reset", int'(units), 0);
        check("R1 tens after reset", int'(tens), 0);
        check("R1 carry after reset", int'(carry), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 idle count", int'(units), 0);

        // R3 R4 R5: two full sweeps through 00..99.
        for (int n = 0; n < 200; n++) begin
            press(DEB + 6);
            if (presses % 10 == 0) check_count("R4");
            else                   check_count("R3");
            if (presses == 100) check("R5 carry count first wrap", carry_seen, 1);
        end
        check("R5 carry count after two wraps", carry_seen, 2);

        // R7: glitches shorter than the debounce window are ignored.
        for (int w = 1; w < DEB; w++) begin
            btn = 1'b1;
            repeat (w) @(posedge clk);
            btn = 1'b0;
            repeat (GAP) @(posedge clk);
            @(negedge clk);
            check_count("R7");
        end

        // R6: long hold gives a single step, release adds nothing.
        btn = 1'b1;
        repeat (300) @(posedge clk);
        @(negedge clk);
        presses++;
        check_count("R6 during hold");
        btn = 1'b0;
        repeat (GAP * 3) @(posedge clk);
        @(negedge clk);
        check_count("R6 after release");

        // R1: reset mid-count clears the digits.
        press(DEB + 6);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 units on reset", int'(units), 0);
        check("R1 tens on reset", int'(tens), 0);
        rst_n = 1'b1;
        presses = 0;
        press(DEB + 6);
        check_count("R1 first press after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule